// File: doc/BRIEF.md
# JTAG Low-Power Mode Controller

This block is a small mode controller that runs entirely on the JTAG test clock. It keeps power control working while the functional clocks are stopped. It watches the instruction value that a user-JTAG port presents in parallel. On each instruction-update strobe it decodes a handful of custom opcodes. The decoded opcode picks one of four modes:

- **Pin-follow.** An external active-low freeze pin decides freeze.
- **Run.** The device is forced active.
- **Freeze.** The controller asserts a freeze request.
- **Authenticate.** An authentication circuit is switched on. That circuit otherwise stays off to save supply current.

Both outputs come from registers. They change only on a test-clock edge. The freeze request goes to a power macro, which freezes the device only when the external pin is also asserted. The authentication enable powers the decryption and authentication logic needed for secure programming.

Top module: `lpm_jtag_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge of `tck`, the controller goes to pin-follow mode, and both `freezeReq` and `authEn` read 0 after that edge.
- R2: An opcode is decoded only at an edge where `irUpdate` is high. With `irUpdate` low, the mode is unchanged whatever `irValue` holds.
- R3: Opcode 0x7E, decoded from any mode, selects Freeze. `freezeReq` is 1 and `authEn` is 0 after that edge, independent of `freezePinN`.
- R4: Opcode 0x7F, decoded from any mode, selects Run. Both outputs are 0 after that edge.
- R5: Opcode 0x7D, decoded from any mode, selects pin-follow. In pin-follow mode, `freezeReq` after each edge equals the inverse of `freezePinN` sampled at that edge, and `authEn` is 0.
- R6: Opcode 0xDD, decoded from any mode, selects Authenticate. `authEn` is 1 and `freezeReq` is 0 after that edge. `authEn` is 1 in no other mode.
- R7: In Authenticate, opcodes 0x0A, 0xDF, 0xFF and 0xDD keep the controller in Authenticate.
- R8: In Authenticate, 0x7E and 0x7D still select Freeze and pin-follow. Every other opcode that is not in the R7 set returns the controller to Run.
- R9: Outside Authenticate, an opcode other than 0x7E, 0x7F, 0x7D or 0xDD leaves the mode unchanged. This includes 0x0A, 0xDF and 0xFF.
- R10: In Run, Freeze and Authenticate, `freezePinN` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| irValue | input | 8 | Instruction register value from the user-JTAG port |
| irUpdate | input | 1 | High for one cycle when a new instruction is valid |
| freezePinN | input | 1 | External freeze pin, active low |
| freezeReq | output | 1 | Registered freeze request to the power macro, active high |
| authEn | output | 1 | Registered authentication circuit enable |

## Verification
In pin-follow mode, an edge can carry both a mode-changing opcode and a change on the freeze pin. The output must then follow the new mode, and the pin must matter only if that new mode is pin-follow.

The bench provokes this case in a sweep. It applies each of the 256 opcodes from each of the four modes, and derives the pin level from the opcode so that the pin often toggles on the same edge. A behavioural model decides the result from the mode after the edge and the pin sampled at that edge. Both outputs are compared against the model on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_PIN  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_FRZ  = 2'd2,
    MODE_AUTH = 2'd3
  } lpmMode_e;

  // strobes from control to the output stage, valid for the mode being entered
  typedef struct packed {
    logic followPin;
    logic holdFreeze;
    logic enableAuth;
  } lpmCtl_t;

endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] OP_FREEZE = 8'h7E,
  parameter logic [IR_W-1:0] OP_RUN    = 8'h7F,
  parameter logic [IR_W-1:0] OP_PIN    = 8'h7D,
  parameter logic [IR_W-1:0] OP_AUTH   = 8'hDD,
  parameter int AUTH_KEEP_N = 3,
  parameter logic [AUTH_KEEP_N*IR_W-1:0] AUTH_KEEP_OPS = {8'hFF, 8'hDF, 8'h0A}
) (
  input  logic            tck,
  input  logic            rst,
  input  logic [IR_W-1:0] irValue,
  input  logic            irUpdate,
  output lpmCtl_t         ctlNext
);

  lpmMode_e modeQ, modeD;
  logic [AUTH_KEEP_N-1:0] keepHit;
  logic isKeep;

  genvar k;
  generate
    for (k = 0; k < AUTH_KEEP_N; k++) begin : g_keep
      assign keepHit[k] = (irValue == AUTH_KEEP_OPS[k*IR_W +: IR_W]);
    end
  endgenerate

  assign isKeep = (|keepHit) || (irValue == OP_AUTH);

  always_comb begin
    modeD = modeQ;
    if (irUpdate) begin
      if (irValue == OP_FREEZE)      modeD = MODE_FRZ;
      else if (irValue == OP_RUN)    modeD = MODE_RUN;
      else if (irValue == OP_PIN)    modeD = MODE_PIN;
      else if (irValue == OP_AUTH)   modeD = MODE_AUTH;
      else if (modeQ == MODE_AUTH && !isKeep) modeD = MODE_RUN;
    end
    if (rst) modeD = MODE_PIN;
  end

  always_ff @(posedge tck) begin
    modeQ <= modeD;
  end

  always_comb begin
    ctlNext.followPin  = (modeD == MODE_PIN);
    ctlNext.holdFreeze = (modeD == MODE_FRZ);
    ctlNext.enableAuth = (modeD == MODE_AUTH);
  end

  p_hold_r2: assert property (@(posedge tck) disable iff (rst)
    !irUpdate |=> $stable(modeQ));

  p_auth_keep_r7: assert property (@(posedge tck) disable iff (rst)
    (modeQ == MODE_AUTH && irUpdate && irValue == AUTH_KEEP_OPS[IR_W-1:0])
      |=> modeQ == MODE_AUTH);

  p_auth_exit_r8: assert property (@(posedge tck) disable iff (rst)
    (modeQ == MODE_AUTH && irUpdate && !isKeep && irValue != OP_FREEZE && irValue != OP_PIN)
      |=> modeQ == MODE_RUN);

  p_other_r9: assert property (@(posedge tck) disable iff (rst)
    (modeQ != MODE_AUTH && irUpdate && irValue != OP_FREEZE && irValue != OP_RUN &&
     irValue != OP_PIN && irValue != OP_AUTH) |=> $stable(modeQ));

endmodule

// File: rtl/lpm_outreg.sv
module lpm_outreg
  import lpm_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  lpmCtl_t ctl,
  input  logic    freezePinN,
  output logic    freezeReq,
  output logic    authEn
);

  always_ff @(posedge tck) begin
    if (rst) begin
      freezeReq <= 1'b0;
      authEn    <= 1'b0;
    end else begin
      freezeReq <= ctl.holdFreeze || (ctl.followPin && !freezePinN);
      authEn    <= ctl.enableAuth;
    end
  end

  p_reset_r1: assert property (@(posedge tck)
    rst |=> (!freezeReq && !authEn));

  p_pin_follow_r5: assert property (@(posedge tck) disable iff (rst)
    ctl.followPin |=> (freezeReq == !$past(freezePinN)));

  p_excl_r6: assert property (@(posedge tck) disable iff (rst)
    authEn |-> !freezeReq);

  p_pin_ignored_r10: assert property (@(posedge tck) disable iff (rst)
    !ctl.followPin |=> freezeReq == $past(ctl.holdFreeze));

endmodule

// File: rtl/lpm_jtag_ctrl.sv
module lpm_jtag_ctrl
  import lpm_pkg::*;
#(
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] OP_FREEZE = 8'h7E,
  parameter logic [IR_W-1:0] OP_RUN    = 8'h7F,
  parameter logic [IR_W-1:0] OP_PIN    = 8'h7D,
  parameter logic [IR_W-1:0] OP_AUTH   = 8'hDD,
  parameter int AUTH_KEEP_N = 3,
  parameter logic [AUTH_KEEP_N*IR_W-1:0] AUTH_KEEP_OPS = {8'hFF, 8'hDF, 8'h0A}
) (
  input  logic            tck,
  input  logic            rst,
  input  logic [IR_W-1:0] irValue,
  input  logic            irUpdate,
  input  logic            freezePinN,
  output logic            freezeReq,
  output logic            authEn
);

  lpmCtl_t ctlNext;

  lpm_fsm #(
    .IR_W(IR_W), .OP_FREEZE(OP_FREEZE), .OP_RUN(OP_RUN), .OP_PIN(OP_PIN),
    .OP_AUTH(OP_AUTH), .AUTH_KEEP_N(AUTH_KEEP_N), .AUTH_KEEP_OPS(AUTH_KEEP_OPS)
  ) i_fsm (
    .tck(tck), .rst(rst), .irValue(irValue), .irUpdate(irUpdate), .ctlNext(ctlNext)
  );

  lpm_outreg i_out (
    .tck(tck), .rst(rst), .ctl(ctlNext), .freezePinN(freezePinN),
    .freezeReq(freezeReq), .authEn(authEn)
  );

  p_freeze_r3: assert property (@(posedge tck) disable iff (rst)
    (irUpdate && irValue == OP_FREEZE) |=> (freezeReq && !authEn));

  p_run_r4: assert property (@(posedge tck) disable iff (rst)
    (irUpdate && irValue == OP_RUN) |=> (!freezeReq && !authEn));

  p_auth_r6: assert property (@(posedge tck) disable iff (rst)
    (irUpdate && irValue == OP_AUTH) |=> (authEn && !freezeReq));

endmodule

// File: tb/test_lpm_jtag_ctrl.sv
`timescale 1ns/1ps
module test_lpm_jtag_ctrl;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irValue = 8'h00;
  logic irUpdate = 1'b0;
  logic freezePinN = 1'b1;
  logic freezeReq, authEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model: 0 pin-follow, 1 run, 2 freeze, 3 authenticate
  int mMode = 0;
  logic mFz = 1'b0;
  logic mAu = 1'b0;

  always #2 tck = ~tck;

  lpm_jtag_ctrl i_lpm_jtag_ctrl (
    .tck(tck), .rst(rst), .irValue(irValue), .irUpdate(irUpdate),
    .freezePinN(freezePinN), .freezeReq(freezeReq), .authEn(authEn)
  );

  function automatic bit inKeep(input logic [7:0] o);
    return (o == 8'h0A) || (o == 8'hDF) || (o == 8'hFF) || (o == 8'hDD);
  endfunction

  function automatic string tagFor(input int m, input logic [7:0] o);
    if (o == 8'h7E) return "R3";
    if (o == 8'h7F) return "R4";
    if (o == 8'h7D) return "R5";
    if (o == 8'hDD) return "R6";
    if (m == 3) return inKeep(o) ? "R7" : "R8";
    return "R9";
  endfunction

  task automatic tick(input logic r, input logic u, input logic [7:0] o,
                      input logic p, input string tag);
    rst = r; irUpdate = u; irValue = o; freezePinN = p;
    @(posedge tck);
    if (r) mMode = 0;
    else if (u) begin
      case (o)
        8'h7E: mMode = 2;
        8'h7F: mMode = 1;
        8'h7D: mMode = 0;
        8'hDD: mMode = 3;
        default: if (mMode == 3 && !inKeep(o)) mMode = 1;
      endcase
    end
    mFz = !r && ((mMode == 2) || (mMode == 0 && !p));
    mAu = !r && (mMode == 3);
    @(negedge tck);
    total++;
    if (freezeReq !== mFz || authEn !== mAu) begin
      bad++;
      $display("FAIL %s: freezeReq=%b authEn=%b expected freezeReq=%b authEn=%b (op=%h upd=%b pin=%b)",
               tag, freezeReq, authEn, mFz, mAu, o, u, p);
    end
  endtask

  task automatic enterMode(input int m);
    tick(1'b1, 1'b0, 8'h00, 1'b1, "R1");
    case (m)
      1: tick(1'b0, 1'b1, 8'h7F, 1'b0, "R4");
      2: tick(1'b0, 1'b1, 8'h7E, 1'b1, "R3");
      3: tick(1'b0, 1'b1, 8'hDD, 1'b0, "R6");
      default: tick(1'b0, 1'b0, 8'h00, 1'b0, "R5");
    endcase
  endtask

  initial begin
    @(negedge tck);
    tick(1'b1, 1'b0, 8'h7E, 1'b0, "R1");
    tick(1'b1, 1'b1, 8'hDD, 1'b0, "R1");
    // pin-follow after reset
    tick(1'b0, 1'b0, 8'h00, 1'b0, "R5");
    tick(1'b0, 1'b0, 8'h00, 1'b1, "R5");
    tick(1'b0, 1'b0, 8'h7E, 1'b0, "R2");
    // every opcode from every mode
    for (int m = 0; m < 4; m++) begin
      for (int op = 0; op < 256; op++) begin
        enterMode(m);
        tick(1'b0, 1'b1, 8'(op), op[0], tagFor(m, 8'(op)));
        tick(1'b0, 1'b0, 8'(op ^ 8'h5A), ~op[0], "R2");
      end
    end
    // pin ignored outside pin-follow
    for (int m = 1; m < 4; m++) begin
      enterMode(m);
      for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 8'h7D, i[0], "R10");
    end
    // authenticate held through a keep sequence, then dropped to run
    enterMode(3);
    tick(1'b0, 1'b1, 8'h0A, 1'b0, "R7");
    tick(1'b0, 1'b1, 8'hDF, 1'b0, "R7");
    tick(1'b0, 1'b1, 8'hFF, 1'b0, "R7");
    tick(1'b0, 1'b1, 8'h12, 1'b0, "R8");
    tick(1'b0, 1'b1, 8'h0A, 1'b0, "R9");
    // reset in the middle of freeze
    enterMode(2);
    tick(1'b1, 1'b1, 8'h7E, 1'b1, "R1");
    tick(1'b0, 1'b0, 8'h00, 1'b0, "R5");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule